// File: doc/BRIEF.md
# Mode-Configurable Sum-of-Products Macrocell Array

This block is a small programmable logic array. Eight output macrocells are fed from a shared AND array, and each macrocell owns eight product terms. A fuse map, presented as a static configuration input, decides which true or complemented array inputs each product term uses. The array sees eight dedicated data inputs and eight feedback slots. The contents of the feedback slots depend on the global mode and on each macrocell's kind.

A two-bit global mode field selects one of three arrangements: registered, complex or simple. The mode decides four things: what the two auxiliary pins (pin-1 role and pin-11 role) do, which source drives each feedback slot, and whether product term 0 acts as an output enable or as an extra OR input. A two-bit kind per macrocell chooses dedicated input, combinatorial I/O, registered output or combinatorial output without feedback. A polarity bit per macrocell selects true or inverted combinatorial drive. The block drives data and an enable for each of the eight I/O pins, and it reads the pin levels back through `io_in`.

Top module: `pal_macrocell_array`

## Requirements
- R1: While reset is low, and until the first clock edge after reset, every register holds 0. A registered-kind macrocell in registered mode therefore drives 1.
- R2: Row bit 2k of a product term's fuse row connects array input k true, and bit 2k+1 connects it complemented (1 = connected). Array inputs 0..7 are `in_ded`, and 8+s is feedback slot s. A term is the AND of its connected literals, so a row with nothing connected gives 1 and a row with every literal connected gives 0.
- R3: Registered mode is `cfg_mode`=2'b10. There a macrocell of kind 2'b10 loads the OR of all eight terms on each rising clock edge, drives the inverted register value, and is enabled exactly when `in_p11_n` is low.
- R4: In registered mode, a kind 2'b01 or 2'b11 macrocell is enabled by term 0 and drives the OR of terms 1..7. It drives that OR true when its polarity bit is 1 and inverted when the bit is 0.
- R5: A kind 2'b00 macrocell (dedicated input) is never enabled, except at a centre position in simple mode. Its pin level still reaches its feedback slot.
- R6: Complex mode is `cfg_mode`=2'b01. Term 0 is the enable and terms 1..7 the sum. Slot 0 carries `in_p1`, slot 7 carries `in_p11_n`, and slots 1..6 carry the pin of the same macrocell.
- R7: Simple mode is `cfg_mode`=2'b00 or 2'b11. All eight terms are summed, and every macrocell not of input kind is always enabled. Macrocells 3 and 4 are always enabled outputs whatever their kind. Slot 0 carries `in_p1` and slot 7 carries `in_p11_n`. Slots 1,2,3 take the pins of macrocells 0,1,2, and slots 4,5,6 take the pins of macrocells 5,6,7.
- R8: A kind 2'b11 macrocell puts 0 on the feedback slot that would otherwise carry its pin level.
- R9: In registered mode, slot m carries register m for a registered-kind macrocell and pin m otherwise. The auxiliary pins do not reach the array.
- R10: A register loads only in registered mode with registered kind. Otherwise it keeps its value across mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock (pin-1 role in registered mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Global mode: 00/11 simple, 01 complex, 10 registered |
| cfg_kind | input | 16 | Two bits per macrocell, macrocell m at [2m+1:2m] |
| cfg_pol | input | 8 | Per-macrocell combinatorial polarity, 1 = true |
| cfg_fuse | input | 2048 | Fuse rows; term t of macrocell m starts at bit (m*8+t)*32 |
| in_ded | input | 8 | Dedicated array inputs |
| in_p1 | input | 1 | Auxiliary input, array input in complex/simple modes |
| in_p11_n | input | 1 | Shared active-low enable in registered mode, array input otherwise |
| io_in | input | 8 | Level read back from each I/O pin |
| io_out | output | 8 | Data driven to each I/O pin |
| io_oe | output | 8 | Drive enable for each I/O pin |

## Verification
On every cycle the assertions check how the enables follow mode and kind: an input-kind pin stays disabled, registered pins follow the shared enable pin, and in simple mode every output pin, centre pins included, stays enabled. They also check that registered outputs read high on the first edge after reset. Product-term evaluation, the slot routing in each mode, feedback suppression, polarity, register loading and holding across mode changes depend on the fuse contents. Only the bench's sweeps can show those, by driving known fuse rows and one-hot sources.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        MODE_SIMPLE     = 2'b00,
        MODE_COMPLEX    = 2'b01,
        MODE_REGISTERED = 2'b10,
        MODE_SIMPLE_ALT = 2'b11
    } pal_mode_e;

    typedef enum logic [1:0] {
        KIND_INPUT    = 2'b00,
        KIND_COMB_IO  = 2'b01,
        KIND_REG      = 2'b10,
        KIND_COMB_OUT = 2'b11
    } mc_kind_e;

    function automatic logic is_simple(input logic [1:0] mode);
        return (mode == MODE_SIMPLE) || (mode == MODE_SIMPLE_ALT);
    endfunction
endpackage

// File: rtl/pal_and_array.sv
module pal_and_array #(
    parameter int NUM_IN = 16,
    parameter int TERMS  = 8,
    localparam int ROW_W = 2 * NUM_IN
) (
    input  logic [NUM_IN-1:0]       arr_in,
    input  logic [TERMS*ROW_W-1:0]  rows,
    output logic [TERMS-1:0]        pterm
);
    logic [ROW_W-1:0] literals;

    always_comb begin
        for (int k = 0; k < NUM_IN; k++) begin
            literals[2*k]   = arr_in[k];
            literals[2*k+1] = ~arr_in[k];
        end
    end

    // A connected literal (row bit 1) must be high; unconnected ones pass.
    for (genvar t = 0; t < TERMS; t++) begin : g_term
        assign pterm[t] = &(~rows[t*ROW_W +: ROW_W] | literals);
    end
endmodule

// File: rtl/pal_feedback_route.sv
module pal_feedback_route
    import pal_pkg::*;
#(
    parameter int NUM_MC = 8
) (
    input  logic [1:0]          mode,
    input  logic [2*NUM_MC-1:0] kind,
    input  logic [NUM_MC-1:0]   reg_q,
    input  logic [NUM_MC-1:0]   io_in,
    input  logic                aux_a,
    input  logic                aux_b,
    output logic [NUM_MC-1:0]   slot
);
    localparam int CTR_LO = NUM_MC / 2 - 1;
    localparam int CTR_HI = NUM_MC / 2;

    logic [NUM_MC-1:0] pin_src;

    always_comb begin
        for (int m = 0; m < NUM_MC; m++) begin
            pin_src[m] = (kind[2*m +: 2] == KIND_COMB_OUT) ? 1'b0 : io_in[m];
        end
    end

    always_comb begin
        slot = '0;
        if (mode == MODE_REGISTERED) begin
            for (int m = 0; m < NUM_MC; m++) begin
                slot[m] = (kind[2*m +: 2] == KIND_REG) ? reg_q[m] : pin_src[m];
            end
        end else if (mode == MODE_COMPLEX) begin
            for (int m = 1; m < NUM_MC - 1; m++) begin
                slot[m] = pin_src[m];
            end
            slot[0]        = aux_a;
            slot[NUM_MC-1] = aux_b;
        end else begin
            for (int m = 0; m < NUM_MC; m++) begin
                if (m < CTR_LO) begin
                    slot[m+1] = pin_src[m];
                end else if (m > CTR_HI) begin
                    slot[m-1] = pin_src[m];
                end
            end
            slot[0]        = aux_a;
            slot[NUM_MC-1] = aux_b;
        end
    end
endmodule

// File: rtl/pal_output_select.sv
module pal_output_select
    import pal_pkg::*;
#(
    parameter int TERMS     = 8,
    parameter bit IS_CENTRE = 1'b0
) (
    input  logic [1:0]       mode,
    input  logic [1:0]       kind,
    input  logic             pol,
    input  logic [TERMS-1:0] pterm,
    input  logic             reg_bit,
    input  logic             oe_pin_n,
    output logic             load_val,
    output logic             drive,
    output logic             oe
);
    logic sum_all;
    logic sum_tail;

    assign sum_all  = |pterm;
    assign sum_tail = |pterm[TERMS-1:1];
    assign load_val = sum_all;

    always_comb begin
        drive = 1'b0;
        oe    = 1'b0;
        if (mode == MODE_REGISTERED) begin
            if (kind == KIND_REG) begin
                drive = ~reg_bit;
                oe    = ~oe_pin_n;
            end else if (kind != KIND_INPUT) begin
                drive = pol ? sum_tail : ~sum_tail;
                oe    = pterm[0];
            end
        end else if (mode == MODE_COMPLEX) begin
            if (kind != KIND_INPUT) begin
                drive = pol ? sum_tail : ~sum_tail;
                oe    = pterm[0];
            end
        end else begin
            if (IS_CENTRE || kind != KIND_INPUT) begin
                drive = pol ? sum_all : ~sum_all;
                oe    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pal_macrocell_array.sv
module pal_macrocell_array
    import pal_pkg::*;
#(
    parameter int NUM_MC  = 8,
    parameter int NUM_DED = 8,
    parameter int TERMS   = 8,
    localparam int NUM_IN = NUM_DED + NUM_MC,
    localparam int ROW_W  = 2 * NUM_IN,
    localparam int MC_W   = TERMS * ROW_W,
    localparam int FUSE_W = NUM_MC * MC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_mode,
    input  logic [2*NUM_MC-1:0] cfg_kind,
    input  logic [NUM_MC-1:0]   cfg_pol,
    input  logic [FUSE_W-1:0]   cfg_fuse,
    input  logic [NUM_DED-1:0]  in_ded,
    input  logic                in_p1,
    input  logic                in_p11_n,
    input  logic [NUM_MC-1:0]   io_in,
    output logic [NUM_MC-1:0]   io_out,
    output logic [NUM_MC-1:0]   io_oe
);
    typedef struct packed {
        logic [NUM_MC-1:0] reg_bits;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [NUM_MC-1:0] slot;
    logic [NUM_IN-1:0] arr_in;
    logic [NUM_MC-1:0] load_val;

    pal_feedback_route #(.NUM_MC(NUM_MC)) u_route (
        .mode  (cfg_mode),
        .kind  (cfg_kind),
        .reg_q (state_q.reg_bits),
        .io_in (io_in),
        .aux_a (in_p1),
        .aux_b (in_p11_n),
        .slot  (slot)
    );

    assign arr_in = {slot, in_ded};

    for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
        logic [TERMS-1:0] pterm;

        pal_and_array #(.NUM_IN(NUM_IN), .TERMS(TERMS)) u_and (
            .arr_in (arr_in),
            .rows   (cfg_fuse[m*MC_W +: MC_W]),
            .pterm  (pterm)
        );

        pal_output_select #(
            .TERMS     (TERMS),
            .IS_CENTRE ((m == NUM_MC/2 - 1) || (m == NUM_MC/2))
        ) u_sel (
            .mode     (cfg_mode),
            .kind     (cfg_kind[2*m +: 2]),
            .pol      (cfg_pol[m]),
            .pterm    (pterm),
            .reg_bit  (state_q.reg_bits[m]),
            .oe_pin_n (in_p11_n),
            .load_val (load_val[m]),
            .drive    (io_out[m]),
            .oe       (io_oe[m])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int m = 0; m < NUM_MC; m++) begin
            if (cfg_mode == MODE_REGISTERED && cfg_kind[2*m +: 2] == KIND_REG) begin
                state_d.reg_bits[m] = load_val[m];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/pal_macrocell_array_chk.sv
module pal_macrocell_array_chk
    import pal_pkg::*;
#(
    parameter int NUM_MC = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cfg_mode,
    input logic [2*NUM_MC-1:0] cfg_kind,
    input logic                in_p11_n,
    input logic [NUM_MC-1:0]   io_out,
    input logic [NUM_MC-1:0]   io_oe
);
    for (genvar m = 0; m < NUM_MC; m++) begin : g_chk
        localparam bit CENTRE = (m == NUM_MC/2 - 1) || (m == NUM_MC/2);

        // R5: dedicated-input pins stay disabled (simple-mode centres excepted)
        a_r5_input_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_kind[2*m +: 2] == KIND_INPUT && !(is_simple(cfg_mode) && CENTRE))
            |-> !io_oe[m]);

        // R3: registered pins follow the shared active-low enable pin
        a_r3_reg_oe_pin: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode == MODE_REGISTERED && cfg_kind[2*m +: 2] == KIND_REG)
            |-> (io_oe[m] == !in_p11_n));

        // R7: simple mode keeps every output pin and both centres enabled
        a_r7_simple_enabled: assert property (@(posedge clk) disable iff (!rst_n)
            (is_simple(cfg_mode) && (CENTRE || cfg_kind[2*m +: 2] != KIND_INPUT))
            |-> io_oe[m]);

        // R1: registered outputs read high on the first edge out of reset
        a_r1_reg_high_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(rst_n) && cfg_mode == MODE_REGISTERED && cfg_kind[2*m +: 2] == KIND_REG)
            |-> io_out[m]);
    end
endmodule

bind pal_macrocell_array pal_macrocell_array_chk #(.NUM_MC(NUM_MC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .cfg_kind (cfg_kind),
    .in_p11_n (in_p11_n),
    .io_out   (io_out),
    .io_oe    (io_oe)
);

// File: tb/pal_macrocell_array_tb.sv
module pal_macrocell_array_tb;
    localparam int NMC    = 8;
    localparam int NDED   = 8;
    localparam int NT     = 8;
    localparam int ROW_W  = 2 * (NDED + NMC);
    localparam int FUSE_W = NMC * NT * ROW_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cfg_mode = 2'b00;
    logic [2*NMC-1:0] cfg_kind = '0;
    logic [NMC-1:0]  cfg_pol = '1;
    logic [FUSE_W-1:0] fuse = '1;
    logic [NDED-1:0] in_ded = '0;
    logic            in_p1 = 1'b0;
    logic            in_p11_n = 1'b0;
    logic [NMC-1:0]  io_in = '0;
    logic [NMC-1:0]  io_out;
    logic [NMC-1:0]  io_oe;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pal_macrocell_array u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_kind(cfg_kind),
        .cfg_pol(cfg_pol), .cfg_fuse(fuse), .in_ded(in_ded), .in_p1(in_p1),
        .in_p11_n(in_p11_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic set_kind(input int m, input logic [1:0] k);
        cfg_kind[2*m +: 2] = k;
    endtask

    function automatic int lit_true(input int idx);
        return 2 * idx;
    endfunction

    task automatic row_blank(input int m, input int t);
        fuse[(m*NT + t)*ROW_W +: ROW_W] = '0;
    endtask

    task automatic row_add(input int m, input int t, input int lit);
        fuse[(m*NT + t)*ROW_W + lit] = 1'b1;
    endtask

    task automatic row_only(input int m, input int t, input int lit);
        row_blank(m, t);
        row_add(m, t, lit);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Simple-mode source of each feedback slot: 0..7 = io_in index, 8 = in_p1, 9 = in_p11_n
    function automatic int simple_src(input int s);
        case (s)
            0: return 8;
            1: return 0;
            2: return 1;
            3: return 2;
            4: return 5;
            5: return 6;
            6: return 7;
            default: return 9;
        endcase
    endfunction

    task automatic drive_src(input int j);
        io_in    = '0;
        in_p1    = 1'b0;
        in_p11_n = 1'b0;
        if (j < 8) io_in[j] = 1'b1;
        else if (j == 8) in_p1 = 1'b1;
        else if (j == 9) in_p11_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // ---------- Registered mode: reset, load, feedback, polarity, hold ----------
        cfg_mode = 2'b10;
        cfg_kind = '0;
        set_kind(0, 2'b10);
        set_kind(1, 2'b01);
        set_kind(2, 2'b01);
        set_kind(3, 2'b01);
        cfg_pol = '1;
        cfg_pol[2] = 1'b0;
        fuse = '1;
        row_only(0, 0, lit_true(0));          // D0 = in_ded[0]
        row_blank(1, 0);                       // enable always on
        row_only(1, 1, lit_true(8));           // slot 0 = reg 0
        row_blank(2, 0);
        row_only(2, 1, lit_true(8));
        row_only(3, 0, lit_true(1));           // enable = in_ded[1]
        row_blank(3, 1);                       // sum = 1
        in_ded = '0;
        in_p11_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(io_out[0], 1'b1, "R1 reg out high in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(io_out[0], 1'b1, "R1 reg out high after reset");
        chk(io_oe[0], 1'b1, "R3 oe with pin low");
        chk(io_out[1], 1'b0, "R9 feedback of reg 0");
        chk(io_out[2], 1'b1, "R4 inverted polarity");
        in_p11_n = 1'b1;
        #1;
        chk(io_oe[0], 1'b0, "R3 oe with pin high");
        in_p11_n = 1'b0;
        in_ded[1] = 1'b0;
        #1;
        chk(io_oe[3], 1'b0, "R4 term0 enable low");
        in_ded[1] = 1'b1;
        #1;
        chk(io_oe[3], 1'b1, "R4 term0 enable high");
        chk(io_out[3], 1'b1, "R4 sum of terms 1..7");
        chk(io_oe[4], 1'b0, "R5 input kind disabled in registered mode");
        in_ded[0] = 1'b1;
        #1;
        chk(io_out[0], 1'b1, "R3 no change before edge");
        tick();
        chk(io_out[0], 1'b0, "R3 loaded 1 drives 0");
        chk(io_out[1], 1'b1, "R9 feedback follows reg");
        chk(io_out[2], 1'b0, "R4 inverted polarity after load");
        // R10: hold across a mode change
        cfg_mode = 2'b01;
        in_ded[0] = 1'b0;
        tick();
        tick();
        cfg_mode = 2'b10;
        #1;
        chk(io_out[0], 1'b0, "R10 register kept outside registered mode");
        tick();
        chk(io_out[0], 1'b1, "R3 reload 0 drives 1");

        // ---------- Simple mode: AND array sweep ----------
        cfg_mode = 2'b00;
        cfg_kind = {NMC{2'b01}};
        cfg_pol = '1;
        cfg_pol[6] = 1'b0;
        fuse = '1;
        row_only(0, 0, lit_true(0));
        row_add(0, 0, lit_true(1));           // a0 & a1
        row_only(1, 0, lit_true(2) + 1);      // ~a2
        row_blank(2, 0);                      // constant 1
        row_only(6, 0, lit_true(0));          // a0, inverted polarity
        io_in = '0;
        in_p1 = 1'b0;
        in_p11_n = 1'b0;
        for (int v = 0; v < 16; v++) begin
            in_ded = 8'(v);
            #1;
            chk(io_out[0], in_ded[0] & in_ded[1], "R2 two-literal AND");
            chk(io_out[1], ~in_ded[2], "R2 complement literal");
            chk(io_out[2], 1'b1, "R2 blank row is one");
            chk(io_out[5], 1'b0, "R2 full row is zero");
            chk(io_out[6], ~in_ded[0], "R7 polarity in simple mode");
            chk(&io_oe, 1'b1, "R7 all outputs enabled");
        end

        // ---------- Simple mode: slot routing with one-hot sources ----------
        in_ded = '0;
        set_kind(3, 2'b00);                   // centre with input kind
        for (int s = 0; s < 8; s++) begin
            fuse[3*NT*ROW_W +: NT*ROW_W] = '1;
            row_only(3, 0, lit_true(8 + s));
            for (int j = 0; j < 11; j++) begin
                drive_src(j);
                #1;
                chk(io_out[3], (j == simple_src(s)), $sformatf("R7 slot %0d source %0d", s, j));
            end
        end
        chk(io_oe[3], 1'b1, "R7 centre forced enabled");
        // R8: comb output without feedback
        fuse[3*NT*ROW_W +: NT*ROW_W] = '1;
        row_only(3, 0, lit_true(9));          // slot 1 = pin of macrocell 0
        drive_src(0);
        #1;
        chk(io_out[3], 1'b1, "R8 io kind feeds back");
        set_kind(0, 2'b11);
        #1;
        chk(io_out[3], 1'b0, "R8 output kind gives no feedback");
        cfg_mode = 2'b11;
        #1;
        chk(io_oe[0], 1'b1, "R7 alternate simple code");

        // ---------- Complex mode ----------
        cfg_mode = 2'b01;
        cfg_kind = '0;
        set_kind(1, 2'b01);
        set_kind(2, 2'b01);
        cfg_pol = '1;
        fuse = '1;
        row_only(1, 0, lit_true(8));          // enable = slot0 = in_p1
        row_only(1, 1, lit_true(10));         // sum = slot2 = pin 2
        row_blank(2, 0);
        row_only(2, 1, lit_true(15));         // slot7 = in_p11_n
        row_only(2, 2, lit_true(12));         // slot4 = pin 4 (input kind)
        for (int v = 0; v < 16; v++) begin
            drive_src(10);
            in_p1    = v[0];
            io_in[2] = v[1];
            in_p11_n = v[2];
            io_in[4] = v[3];
            #1;
            chk(io_oe[1], v[0], "R6 term0 enable from pin-1 slot");
            chk(io_out[1], v[1], "R6 middle pin feedback");
            chk(io_out[2], v[2] | v[3], "R6 pin-11 slot and R5 input feedback");
            chk(io_oe[4], 1'b0, "R5 input kind disabled in complex mode");
        end

        finish_run();
    end
endmodule